// File: doc/BRIEF.md
# Left/Center Aligned PWM Channel

This block is a single pulse-width modulation channel built around a parameterised up/down counter. The counter advances once per clock-enable tick, which comes from a clock selector or prescaler outside the block. Two alignment modes are supported.

- **Left-aligned mode.** The counter climbs from zero to one below the active period and then wraps.
- **Center-aligned mode.** The counter climbs from zero to the active period and then descends back to zero, forming a triangle.

The output starts each period at the level chosen by the polarity input. It flips to the opposite level where the count crosses the active duty value.

Software writes period and duty values into buffer registers. Those values move into the active registers only at a period boundary, which keeps a running waveform free of glitches. Two other events also move them:

- A write to the counter, whatever the data, restarts the channel at once and transfers both buffers immediately.
- While the channel is disabled, the counter sits at zero, the active registers track the buffers, and the output rests at its inactive level.

Top module: `aligned_pwm_chan`

## Requirements
- R1: While reset is asserted, and right after it, the counter read port shows 0. The period and duty registers, both buffered and active, hold 0.
- R2: With `centerMode`=0 and `chanEn`=1, each cycle with `tick`=1 advances the count by one. After reaching period−1 the count wraps to 0, so it runs 0,1,…,P−1,0. A cycle with `tick`=0 leaves the count unchanged.
- R3: With `centerMode`=1 and `chanEn`=1, the count runs 0,1,…,P,P−1,…,1,0,1,… on successive ticks.
- R4: A cycle with `cntWrEn`=1 sets the count to 0 and the direction to up, whatever the data. In that same cycle it copies the period and duty buffers into the active registers. If a buffer is written in that same cycle, the newly written value is the one copied.
- R5: While the channel runs, a new buffered period or duty value takes effect only on the tick that returns the count to 0.
- R6: In left-aligned mode, `pwmOut` equals `polHigh` while count < active duty, and equals the inverse of `polHigh` otherwise.
- R7: In center-aligned mode, `pwmOut` equals `polHigh` in two cases: while counting up with count < duty, and while counting down with count ≤ duty. Otherwise it equals the inverse of `polHigh`. The active part of the output therefore spans 2×duty ticks of each 2×period.
- R8: When active duty ≥ active period, or when active period = 0, `pwmOut` stays at `polHigh`. A period of 0 also keeps the count at 0.
- R9: With `chanEn`=0, the count is 0 on the following cycle and stays there, and `pwmOut` is the inverse of `polHigh`. While disabled, the active registers follow the buffers, so a period written during that time governs the run that starts when the channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock-enable tick that advances the counter |
| centerMode | input | 1 | 1 = center-aligned, 0 = left-aligned |
| polHigh | input | 1 | Output level at the start of each period |
| chanEn | input | 1 | Channel enable |
| perWrEn | input | 1 | Write strobe for the period buffer |
| perWrData | input | CNT_W | Period buffer write data |
| dutyWrEn | input | 1 | Write strobe for the duty buffer |
| dutyWrData | input | CNT_W | Duty buffer write data |
| cntWrEn | input | 1 | Counter write strobe (restart; data ignored) |
| cntRd | output | CNT_W | Counter read value |
| pwmOut | output | 1 | PWM waveform |

## Verification
The bench builds the channel with the default 8-bit counter and uses small periods of 0 to 6. With these periods every wrap, turnaround and buffer reload happens within a few dozen ticks. This setup puts within reach the corners of the full counter range:

- a period of zero
- a duty of zero
- a duty above the period
- a counter write landing in the falling half of a triangle
- a period changed while the channel is disabled

// File: rtl/aligned_pwm_pkg.sv
package aligned_pwm_pkg;

  // Strobes from control to datapath, one decision per cycle.
  typedef struct packed {
    logic clr;      // force count to zero
    logic inc;      // count up by one
    logic dec;      // count down by one
    logic load;     // move buffers into active registers
    logic setDown;  // next move is downward
    logic clrDown;  // next move is upward
  } pwm_strobe_t;

endpackage

// File: rtl/aligned_pwm_ctrl.sv
module aligned_pwm_ctrl
  import aligned_pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             chanEn,
  input  logic             tick,
  input  logic             cntWrEn,
  input  logic             centerMode,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] perAct,
  input  logic             dirDown,
  output pwm_strobe_t      st
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W:0] cntPlus1;
  logic [CNT_W:0] perWide;

  assign cntPlus1 = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign perWide  = {1'b0, perAct};

  always_comb begin
    st = '0;
    if (cntWrEn || !chanEn) begin
      // restart or idle: zero, upward, buffers transferred (R4, R9)
      st.clr     = 1'b1;
      st.load    = 1'b1;
      st.clrDown = 1'b1;
    end else if (tick) begin
      if (perAct == '0) begin
        st.clr     = 1'b1;
        st.load    = 1'b1;
        st.clrDown = 1'b1;
      end else if (!centerMode) begin
        st.clrDown = 1'b1;
        if (cntPlus1 >= perWide) begin
          st.clr  = 1'b1;        // wrap at period-1 (R2), reload (R5)
          st.load = 1'b1;
        end else begin
          st.inc = 1'b1;
        end
      end else if (!dirDown) begin
        if (cnt >= perAct) begin
          st.dec     = 1'b1;
          st.setDown = 1'b1;
        end else begin
          st.inc = 1'b1;
          if (cntPlus1 == perWide) st.setDown = 1'b1;  // turnaround (R3)
        end
      end else begin
        if (cnt <= ONE) begin
          st.clr     = 1'b1;     // back at zero: new period (R5)
          st.load    = 1'b1;
          st.clrDown = 1'b1;
        end else begin
          st.dec = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/aligned_pwm_dp.sv
module aligned_pwm_dp
  import aligned_pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwm_strobe_t      st,
  input  logic             perWrEn,
  input  logic [CNT_W-1:0] perWrData,
  input  logic             dutyWrEn,
  input  logic [CNT_W-1:0] dutyWrData,
  input  logic             centerMode,
  input  logic             polHigh,
  input  logic             chanEn,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] perAct,
  output logic             dirDown,
  output logic             pwmOut
);

  logic [CNT_W-1:0] perBuf, dutyBuf, dutyAct;
  logic [CNT_W-1:0] perNext, dutyNext;
  logic             activeLvl;

  assign perNext  = perWrEn  ? perWrData  : perBuf;
  assign dutyNext = dutyWrEn ? dutyWrData : dutyBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perBuf  <= '0;
      dutyBuf <= '0;
      perAct  <= '0;
      dutyAct <= '0;
      cnt     <= '0;
      dirDown <= 1'b0;
    end else begin
      perBuf  <= perNext;
      dutyBuf <= dutyNext;
      if (st.load) begin
        perAct  <= perNext;
        dutyAct <= dutyNext;
      end
      if (st.clr)      cnt <= '0;
      else if (st.inc) cnt <= cnt + CNT_W'(1);
      else if (st.dec) cnt <= cnt - CNT_W'(1);
      if (st.clrDown)      dirDown <= 1'b0;
      else if (st.setDown) dirDown <= 1'b1;
    end
  end

  // Waveform: active (polarity level) in the low part of the count (R6, R7, R8)
  always_comb begin
    if (perAct == '0)                activeLvl = 1'b1;
    else if (centerMode && dirDown)  activeLvl = (cnt <= dutyAct);
    else                             activeLvl = (cnt < dutyAct);
  end

  assign pwmOut = (chanEn && activeLvl) ? polHigh : ~polHigh;

  // R3: count never exceeds the active period in either mode
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= perAct);

  // R5: active period only changes together with a return to zero
  p_reload_at_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(perAct) |-> cnt == '0);

endmodule

// File: rtl/aligned_pwm_chan.sv
module aligned_pwm_chan
  import aligned_pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             centerMode,
  input  logic             polHigh,
  input  logic             chanEn,
  input  logic             perWrEn,
  input  logic [CNT_W-1:0] perWrData,
  input  logic             dutyWrEn,
  input  logic [CNT_W-1:0] dutyWrData,
  input  logic             cntWrEn,
  output logic [CNT_W-1:0] cntRd,
  output logic             pwmOut
);

  pwm_strobe_t      st;
  logic [CNT_W-1:0] cnt, perAct;
  logic             dirDown;

  aligned_pwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .chanEn     (chanEn),
    .tick       (tick),
    .cntWrEn    (cntWrEn),
    .centerMode (centerMode),
    .cnt        (cnt),
    .perAct     (perAct),
    .dirDown    (dirDown),
    .st         (st)
  );

  aligned_pwm_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .perWrEn    (perWrEn),
    .perWrData  (perWrData),
    .dutyWrEn   (dutyWrEn),
    .dutyWrData (dutyWrData),
    .centerMode (centerMode),
    .polHigh    (polHigh),
    .chanEn     (chanEn),
    .cnt        (cnt),
    .perAct     (perAct),
    .dirDown    (dirDown),
    .pwmOut     (pwmOut)
  );

  assign cntRd = cnt;

  // R4: a counter write restarts at zero
  p_cntwr_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> cntRd == '0);

  // R9: a disabled channel holds its count at zero
  p_disable_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> cntRd == '0);

  // R2: without a tick the running count does not move
  p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && !tick && !cntWrEn) |=> $stable(cntRd));

endmodule

// File: tb/aligned_pwm_chan_test.sv
module aligned_pwm_chan_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0, centerMode = 1'b0, polHigh = 1'b1, chanEn = 1'b0;
  logic       perWrEn = 1'b0, dutyWrEn = 1'b0, cntWrEn = 1'b0;
  logic [7:0] perWrData = '0, dutyWrData = '0;
  logic [7:0] cntRd;
  logic       pwmOut;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  aligned_pwm_chan uut (
    .clk(clk), .rstN(rstN), .tick(tick), .centerMode(centerMode),
    .polHigh(polHigh), .chanEn(chanEn), .perWrEn(perWrEn),
    .perWrData(perWrData), .dutyWrEn(dutyWrEn), .dutyWrData(dutyWrData),
    .cntWrEn(cntWrEn), .cntRd(cntRd), .pwmOut(pwmOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic t);
    tick = t;
    @(posedge clk); #1;
    tick = 1'b0;
  endtask

  task automatic setPer(input int v);
    perWrEn = 1'b1; perWrData = 8'(v);
    step(1'b0);
    perWrEn = 1'b0;
  endtask

  task automatic setDuty(input int v);
    dutyWrEn = 1'b1; dutyWrData = 8'(v);
    step(1'b0);
    dutyWrEn = 1'b0;
  endtask

  task automatic writeCnt();
    cntWrEn = 1'b1;
    step(1'b0);
    cntWrEn = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 count in reset", int'(cntRd), 0);
    chk("R9 output in reset (disabled)", int'(pwmOut), 0);
    rstN = 1'b1;
    step(1'b1);
    chk("R1 count after reset", int'(cntRd), 0);
  endtask

  task automatic tLeft();
    centerMode = 1'b0; polHigh = 1'b1; chanEn = 1'b1;
    setPer(5); setDuty(2); writeCnt();
    for (int k = 0; k < 12; k++) begin
      if (k > 0) step(1'b1);
      chk("R2 left count", int'(cntRd), k % 5);
      chk("R6 left output", int'(pwmOut), ((k % 5) < 2) ? 1 : 0);
    end
    // count is 1 here; no ticks must hold it
    for (int k = 0; k < 3; k++) begin
      step(1'b0);
      chk("R2 hold without tick", int'(cntRd), 1);
    end
  endtask

  task automatic tCenter();
    int cSeq[6] = '{0, 1, 2, 3, 2, 1};
    int oSeq[6] = '{0, 1, 1, 1, 1, 0};
    centerMode = 1'b1; polHigh = 1'b0; chanEn = 1'b1;
    setPer(3); setDuty(1); writeCnt();
    for (int k = 0; k < 13; k++) begin
      if (k > 0) step(1'b1);
      chk("R3 center count", int'(cntRd), cSeq[k % 6]);
      chk("R7 center output", int'(pwmOut), oSeq[k % 6]);
    end
    // k=12 -> count 0; advance into falling half (count 2, down)
    for (int k = 0; k < 4; k++) step(1'b1);
    chk("R3 falling half", int'(cntRd), 2);
    writeCnt();
    chk("R4 center restart count", int'(cntRd), 0);
    for (int k = 1; k <= 3; k++) begin
      step(1'b1);
      chk("R4 direction up after write", int'(cntRd), k);
    end
  endtask

  task automatic tBuffered();
    int exp[9] = '{2, 3, 0, 1, 2, 3, 4, 5, 0};
    centerMode = 1'b0; polHigh = 1'b1; chanEn = 1'b1;
    setPer(4); setDuty(0); writeCnt();
    step(1'b1);
    setPer(6);
    chk("R5 buffer write leaves count", int'(cntRd), 1);
    for (int k = 0; k < 9; k++) begin
      step(1'b1);
      chk("R5 period change at zero", int'(cntRd), exp[k]);
    end
  endtask

  task automatic tCntWrite();
    // active period is 6, count 0
    step(1'b1); step(1'b1);
    setPer(3);
    writeCnt();
    chk("R4 write restarts", int'(cntRd), 0);
    step(1'b1); chk("R4 new period now", int'(cntRd), 1);
    step(1'b1); chk("R4 new period now", int'(cntRd), 2);
    step(1'b1); chk("R4 wrap at new period", int'(cntRd), 0);
  endtask

  task automatic tFullDuty();
    centerMode = 1'b0; polHigh = 1'b1;
    setPer(5); setDuty(7); writeCnt();
    for (int k = 0; k < 10; k++) begin
      step(1'b1);
      chk("R8 left duty above period", int'(pwmOut), 1);
    end
    centerMode = 1'b1;
    setPer(3); setDuty(3); writeCnt();
    for (int k = 0; k < 10; k++) begin
      step(1'b1);
      chk("R8 center duty equals period", int'(pwmOut), 1);
    end
    centerMode = 1'b0;
    setPer(0); setDuty(0); writeCnt();
    for (int k = 0; k < 4; k++) begin
      step(1'b1);
      chk("R8 zero period count", int'(cntRd), 0);
      chk("R8 zero period output", int'(pwmOut), 1);
    end
  endtask

  task automatic tDisable();
    centerMode = 1'b0; polHigh = 1'b1; chanEn = 1'b1;
    setPer(3); setDuty(1); writeCnt();
    step(1'b1);
    chk("R9 running before disable", int'(cntRd), 1);
    chanEn = 1'b0;
    step(1'b1);
    chk("R9 disabled count", int'(cntRd), 0);
    chk("R9 disabled output", int'(pwmOut), 0);
    step(1'b1); step(1'b1);
    chk("R9 disabled holds", int'(cntRd), 0);
    setPer(5);
    chanEn = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      step(1'b1);
      chk("R9 period taken while disabled", int'(cntRd), k % 5);
    end
  endtask

  task automatic tPolarity();
    centerMode = 1'b0; polHigh = 1'b0; chanEn = 1'b1;
    setPer(4); setDuty(1); writeCnt();
    for (int k = 0; k < 8; k++) begin
      if (k > 0) step(1'b1);
      chk("R6 low polarity output", int'(pwmOut), ((k % 4) < 1) ? 0 : 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tReset();
    tLeft();
    tCenter();
    tBuffered();
    tCntWrite();
    tFullDuty();
    tDisable();
    tPolarity();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule